// File: doc/BRIEF.md
# Hierarchical Page Table Walker

This block translates a 64-bit virtual address into a physical address by walking a tree of in-memory translation tables. A request presents a virtual address. The walker looks at a translation-enable bit, a 32-bit translation-control word and two table root registers. It then fetches 8-byte descriptors one at a time over a simple request/valid read port and finishes with a single done pulse. That pulse carries either the physical address or a fault flag.

The top bit of the address picks one of two ranges, each with its own root, size field and granule code. The walker first checks that the unused upper address bits match the chosen range. From the granule (4, 16 or 64 KB) it derives the page-offset width, the per-level index width and the first level of the walk. Every descriptor is checked for a valid table or page encoding before the walk goes on.

With translation disabled, the address passes through unchanged and no memory reads are made.

Top module: `ptw_engine`

## Requirements
- R1: With `xlat_en` low, an accepted request gives `done` in the next cycle with `done_fault` = 0 and `done_paddr` equal to `req_vaddr`, and no read is issued.
- R2: `req_vaddr[63]` = 1 selects the upper range (root `root_hi`, size field `ctl_word[21:16]`, granule field `ctl_word[31:30]`). Otherwise the lower range is used (root `root_lo`, size `ctl_word[5:0]`, granule `ctl_word[15:14]`).
- R3: A size value N defines a (64 - N)-bit space. In the lower range, any 1 among the top N address bits faults in the next cycle without a read.
- R4: In the upper range, any 0 among the top N address bits faults in the next cycle without a read.
- R5: Lower granule code: 00 = 4 KB, 01 = 64 KB, 10 = 16 KB. Code 11 faults in the next cycle without a read.
- R6: Upper granule code: 10 = 4 KB, 01 = 16 KB, 11 = 64 KB. Code 00 faults in the next cycle without a read.
- R7: The offset width W is 12, 14 or 16 and the index width is W - 3. The level-L shift is W + (3 - L)(W - 3). For a 4 KB granule the walk starts at level 0 if the space size exceeds the level-0 shift, otherwise at level 1 if it exceeds the level-1 shift, otherwise at level 2.
- R8: For 16 KB and 64 KB granules the walk starts at level 1 if the space size exceeds the level-1 shift, otherwise at level 2. Every walk ends at level 3.
- R9: Each read address equals the current table base plus 8 times the level-L index. The index is `req_vaddr` shifted right by the level-L shift and masked to W - 3 bits. The first table base is the selected root.
- R10: A descriptor with bits [1:0] not equal to 11 (including 01) ends the walk with `done_fault` = 1, in the cycle after its response.
- R11: A descriptor with bits [1:0] = 11 below level 3 gives the next table base: the descriptor with its low W bits cleared. At level 3 it gives `done_paddr` = descriptor with low W bits cleared, OR-ed with the low W bits of the virtual address, with `done_fault` = 0, in the cycle after the response.
- R12: `req_ready` is high only when idle, and `req_valid` is ignored otherwise. Each accepted request yields exactly one `done` pulse. `mem_rd_req` is a one-cycle pulse. `mem_rd_valid` counts only while a walk waits and `mem_rd_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 64 | Virtual address to translate |
| req_ready | output | 1 | Walker idle, request can be taken |
| xlat_en | input | 1 | Translation enable; low means pass-through |
| ctl_word | input | 32 | Size and granule fields of both ranges |
| root_lo | input | 64 | Root table base of the lower range |
| root_hi | input | 64 | Root table base of the upper range |
| mem_rd_req | output | 1 | Descriptor read request pulse |
| mem_rd_addr | output | 64 | Descriptor byte address |
| mem_rd_valid | input | 1 | Descriptor data valid |
| mem_rd_data | input | 64 | Descriptor data |
| done | output | 1 | Translation finished (one cycle) |
| done_fault | output | 1 | Translation faulted |
| done_paddr | output | 64 | Physical address, zero on fault |

## Verification
The assertions assume that the memory side answers only after the request pulse has dropped, with exactly one `mem_rd_valid` per read. They also assume that `ctl_word`, the roots and `xlat_en` are meaningful in the cycle a request is accepted.

The bench's memory responder meets these assumptions. It raises one valid pulse one to three cycles after each request and never while the request is high. The bench holds the configuration steady for the whole walk. Stray stimulus is limited to deliberate cases the block must ignore: a valid pulse while idle, and a request while busy.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    GRAN_4K  = 2'd0,
    GRAN_16K = 2'd1,
    GRAN_64K = 2'd2
  } gran_e;

  typedef enum logic [1:0] {
    DSC_FAULT = 2'd0,
    DSC_TABLE = 2'd1,
    DSC_PAGE  = 2'd2
  } dsc_kind_e;

  localparam int DESC_SHIFT = 3;
  localparam logic [1:0] LAST_LVL = 2'd3;

  function automatic logic [4:0] gran_off_w(gran_e g);
    case (g)
      GRAN_16K: return 5'd14;
      GRAN_64K: return 5'd16;
      default:  return 5'd12;
    endcase
  endfunction

  function automatic logic [6:0] level_shift(logic [4:0] off_w, logic [1:0] lvl);
    logic [6:0] iw;
    logic [6:0] steps;
    iw    = {2'b00, off_w} - 7'd3;
    steps = {5'b00000, 2'(LAST_LVL - lvl)};
    return {2'b00, off_w} + iw * steps;
  endfunction

endpackage

// File: rtl/ptw_range_decode.sv
module ptw_range_decode
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int SZ_W   = 6,
  parameter int TG_W   = 2
) (
  input  logic [ADDR_W-1:0] va,
  input  logic [SZ_W-1:0]   lo_sz,
  input  logic [SZ_W-1:0]   hi_sz,
  input  logic [TG_W-1:0]   lo_tg,
  input  logic [TG_W-1:0]   hi_tg,
  input  logic [ADDR_W-1:0] root_lo,
  input  logic [ADDR_W-1:0] root_hi,
  output logic              canon_ok,
  output logic              gran_ok,
  output logic [4:0]        off_w,
  output logic [1:0]        start_lvl,
  output logic [ADDR_W-1:0] root
);

  localparam int VS_W = $clog2(ADDR_W + 1);

  logic              upper;
  logic [SZ_W-1:0]   sz;
  logic [VS_W-1:0]   vsize;
  logic [ADDR_W-1:0] top_mask;
  gran_e             gran;
  logic [6:0]        sh0;
  logic [6:0]        sh1;

  assign upper    = va[ADDR_W-1];
  assign sz       = upper ? hi_sz : lo_sz;
  assign vsize    = VS_W'(ADDR_W) - VS_W'(sz);
  assign top_mask = {ADDR_W{1'b1}} << vsize;
  assign canon_ok = upper ? ((va & top_mask) == top_mask) : ((va & top_mask) == '0);
  assign root     = upper ? root_hi : root_lo;

  always_comb begin
    gran    = GRAN_4K;
    gran_ok = 1'b1;
    if (upper) begin
      case (hi_tg)
        2'b10:   gran = GRAN_4K;
        2'b01:   gran = GRAN_16K;
        2'b11:   gran = GRAN_64K;
        default: gran_ok = 1'b0;
      endcase
    end else begin
      case (lo_tg)
        2'b00:   gran = GRAN_4K;
        2'b01:   gran = GRAN_64K;
        2'b10:   gran = GRAN_16K;
        default: gran_ok = 1'b0;
      endcase
    end
  end

  assign off_w = gran_off_w(gran);
  assign sh0   = level_shift(off_w, 2'd0);
  assign sh1   = level_shift(off_w, 2'd1);

  always_comb begin
    if (gran == GRAN_4K && int'(vsize) > int'(sh0))
      start_lvl = 2'd0;
    else if (int'(vsize) > int'(sh1))
      start_lvl = 2'd1;
    else
      start_lvl = 2'd2;
  end

endmodule

// File: rtl/ptw_slot_addr.sv
module ptw_slot_addr
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] va,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [4:0]        off_w,
  input  logic [1:0]        lvl,
  output logic [ADDR_W-1:0] slot_addr
);

  logic [6:0]        sh;
  logic [4:0]        iw;
  logic [ADDR_W-1:0] idx;

  assign sh        = level_shift(off_w, lvl);
  assign iw        = off_w - 5'd3;
  assign idx       = (va >> sh) & ~({ADDR_W{1'b1}} << iw);
  assign slot_addr = tbl_base + (idx << DESC_SHIFT);

endmodule

// File: rtl/ptw_desc_eval.sv
module ptw_desc_eval
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] desc,
  input  logic [1:0]        lvl,
  input  logic [4:0]        off_w,
  output dsc_kind_e         kind,
  output logic [ADDR_W-1:0] base_out
);

  assign base_out = desc & ({ADDR_W{1'b1}} << off_w);

  always_comb begin
    if (desc[1:0] != 2'b11)
      kind = DSC_FAULT;
    else if (lvl == LAST_LVL)
      kind = DSC_PAGE;
    else
      kind = DSC_TABLE;
  end

endmodule

// File: rtl/ptw_engine.sv
module ptw_engine
  import ptw_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int CFG_W     = 32,
  parameter int SZ_W      = 6,
  parameter int TG_W      = 2,
  parameter int LO_SZ_LSB = 0,
  parameter int HI_SZ_LSB = 16,
  parameter int LO_TG_LSB = 14,
  parameter int HI_TG_LSB = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  output logic              req_ready,
  input  logic              xlat_en,
  input  logic [CFG_W-1:0]  ctl_word,
  input  logic [ADDR_W-1:0] root_lo,
  input  logic [ADDR_W-1:0] root_hi,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [ADDR_W-1:0] mem_rd_data,
  output logic              done,
  output logic              done_fault,
  output logic [ADDR_W-1:0] done_paddr
);

  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} st_e;

  st_e               state;
  logic [ADDR_W-1:0] va_q;
  logic [4:0]        off_q;
  logic [1:0]        lvl_q;
  logic              req_q;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q;
  logic              fault_q;
  logic [ADDR_W-1:0] pa_q;

  logic              dec_canon;
  logic              dec_gran_ok;
  logic [4:0]        dec_off;
  logic [1:0]        dec_start;
  logic [ADDR_W-1:0] dec_root;

  logic [ADDR_W-1:0] sa_va;
  logic [ADDR_W-1:0] sa_base;
  logic [4:0]        sa_off;
  logic [1:0]        sa_lvl;
  logic [ADDR_W-1:0] sa_addr;

  dsc_kind_e         dsc_kind;
  logic [ADDR_W-1:0] dsc_base;
  logic              rsp_ok;
  logic [ADDR_W-1:0] page_pa;
  logic              ctl_unused;

  assign ctl_unused = ^{ctl_word[LO_TG_LSB-1:LO_SZ_LSB+SZ_W],
                        ctl_word[HI_TG_LSB-1:HI_SZ_LSB+SZ_W]};

  ptw_range_decode #(.ADDR_W(ADDR_W), .SZ_W(SZ_W), .TG_W(TG_W)) dec_i (
    .va        (req_vaddr),
    .lo_sz     (ctl_word[LO_SZ_LSB +: SZ_W]),
    .hi_sz     (ctl_word[HI_SZ_LSB +: SZ_W]),
    .lo_tg     (ctl_word[LO_TG_LSB +: TG_W]),
    .hi_tg     (ctl_word[HI_TG_LSB +: TG_W]),
    .root_lo   (root_lo),
    .root_hi   (root_hi),
    .canon_ok  (dec_canon),
    .gran_ok   (dec_gran_ok),
    .off_w     (dec_off),
    .start_lvl (dec_start),
    .root      (dec_root)
  );

  always_comb begin
    if (state == ST_IDLE) begin
      sa_va   = req_vaddr;
      sa_base = dec_root;
      sa_off  = dec_off;
      sa_lvl  = dec_start;
    end else begin
      sa_va   = va_q;
      sa_base = dsc_base;
      sa_off  = off_q;
      sa_lvl  = lvl_q + 2'd1;
    end
  end

  ptw_slot_addr #(.ADDR_W(ADDR_W)) slot_i (
    .va        (sa_va),
    .tbl_base  (sa_base),
    .off_w     (sa_off),
    .lvl       (sa_lvl),
    .slot_addr (sa_addr)
  );

  ptw_desc_eval #(.ADDR_W(ADDR_W)) desc_i (
    .desc     (mem_rd_data),
    .lvl      (lvl_q),
    .off_w    (off_q),
    .kind     (dsc_kind),
    .base_out (dsc_base)
  );

  assign rsp_ok  = (state == ST_WAIT) && mem_rd_valid && !req_q;
  assign page_pa = dsc_base | (va_q & ~({ADDR_W{1'b1}} << off_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      va_q    <= '0;
      off_q   <= 5'd12;
      lvl_q   <= 2'd0;
      req_q   <= 1'b0;
      addr_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      pa_q    <= '0;
    end else begin
      done_q <= 1'b0;
      req_q  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            va_q <= req_vaddr;
            if (!xlat_en) begin
              done_q  <= 1'b1;
              fault_q <= 1'b0;
              pa_q    <= req_vaddr;
            end else if (!dec_canon || !dec_gran_ok) begin
              done_q  <= 1'b1;
              fault_q <= 1'b1;
              pa_q    <= '0;
            end else begin
              off_q  <= dec_off;
              lvl_q  <= dec_start;
              req_q  <= 1'b1;
              addr_q <= sa_addr;
              state  <= ST_WAIT;
            end
          end
        end
        default: begin
          if (rsp_ok) begin
            case (dsc_kind)
              DSC_TABLE: begin
                lvl_q  <= lvl_q + 2'd1;
                req_q  <= 1'b1;
                addr_q <= sa_addr;
              end
              DSC_PAGE: begin
                done_q  <= 1'b1;
                fault_q <= 1'b0;
                pa_q    <= page_pa;
                state   <= ST_IDLE;
              end
              default: begin
                done_q  <= 1'b1;
                fault_q <= 1'b1;
                pa_q    <= '0;
                state   <= ST_IDLE;
              end
            endcase
          end
        end
      endcase
    end
  end

  assign req_ready   = (state == ST_IDLE);
  assign mem_rd_req  = req_q;
  assign mem_rd_addr = addr_q;
  assign done        = done_q;
  assign done_fault  = fault_q;
  assign done_paddr  = pa_q;

  // R1
  bypass_result_chk: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid && !xlat_en) |=>
      (done && !done_fault && done_paddr == $past(req_vaddr)));

  // R3
  lo_canon_chk: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid && xlat_en && !req_vaddr[ADDR_W-1] &&
     ((req_vaddr >> (ADDR_W - int'(ctl_word[LO_SZ_LSB +: SZ_W]))) != '0))
      |=> (done && done_fault && !mem_rd_req));

  // R5
  lo_resv_gran_chk: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid && xlat_en && !req_vaddr[ADDR_W-1] &&
     ctl_word[LO_TG_LSB +: TG_W] == 2'b11) |=> (done && done_fault));

  // R6
  hi_resv_gran_chk: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid && xlat_en && req_vaddr[ADDR_W-1] &&
     ctl_word[HI_TG_LSB +: TG_W] == 2'b00) |=> (done && done_fault));

  // R10
  bad_desc_chk: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && mem_rd_valid && !mem_rd_req && !mem_rd_data[0])
      |=> (done && done_fault));

  // R12
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |=> !mem_rd_req);

  // R12
  rd_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> !req_ready);

endmodule

// File: tb/ptw_engine_tb.sv
module ptw_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [63:0] req_vaddr = '0;
  logic        req_ready;
  logic        xlat_en = 1'b0;
  logic [31:0] ctl_word = '0;
  logic [63:0] root_lo = 64'h0000_0000_0800_0000;
  logic [63:0] root_hi = 64'h0000_0000_0900_0000;
  logic        mem_rd_req;
  logic [63:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [63:0] mem_rd_data = '0;
  logic        done;
  logic        done_fault;
  logic [63:0] done_paddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_engine dut_i (
    .clk (clk), .rst (rst),
    .req_valid (req_valid), .req_vaddr (req_vaddr), .req_ready (req_ready),
    .xlat_en (xlat_en), .ctl_word (ctl_word),
    .root_lo (root_lo), .root_hi (root_hi),
    .mem_rd_req (mem_rd_req), .mem_rd_addr (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid), .mem_rd_data (mem_rd_data),
    .done (done), .done_fault (done_fault), .done_paddr (done_paddr)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  logic [63:0] mem_m [logic [63:0]];
  logic [63:0] exp_addr [$];
  logic [63:0] built_addr [$];
  logic [63:0] next_tbl;
  logic [63:0] page_base = 64'h0000_0012_3450_0000;

  bit          exp_done = 0, exp_fault = 0, exp_busy = 0;
  logic [63:0] exp_pa = '0;
  bit          pend_fault = 0;
  logic [63:0] pend_pa = '0;
  bit          resp_wait = 0;
  int          resp_cnt = 0;
  logic [63:0] resp_addr = '0;
  int          lat = 1;
  bit          launch = 0, poke = 0, stray = 0;
  logic [63:0] l_va = '0;
  logic        l_en = 1'b0;
  logic [31:0] l_ctl = '0;
  string       cur_tag = "R12";

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual %h expected %h (cycle %0d)", tag, what, act, expv, cyc);
    end
  endtask

  function automatic logic [31:0] mk_ctl(int n0, int tg0, int n1, int tg1);
    return (32'(tg1) << 30) | (32'(n1) << 16) | (32'(tg0) << 14) | 32'(n0);
  endfunction

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem_m.exists(a) ? mem_m[a] : 64'd0;
  endfunction

  task automatic ref_walk(input logic [63:0] va, input logic en, input logic [31:0] ctl,
                          input bit build, output bit flt, output logic [63:0] pa);
    bit hi;
    int n, vs, off, iw, start;
    int sh[4];
    logic [1:0]  code;
    logic [63:0] gsz, tb, d, a, idx, om;
    flt = 1;
    pa  = '0;
    if (!en) begin flt = 0; pa = va; return; end
    hi = va[63];
    n  = hi ? int'(ctl[21:16]) : int'(ctl[5:0]);
    vs = 64 - n;
    for (int b = vs; b < 64; b++) if (va[b] !== hi) return;
    code = hi ? ctl[31:30] : ctl[15:14];
    gsz  = 0;
    if (!hi) begin
      if (code == 2'd0) gsz = 4096; else if (code == 2'd1) gsz = 65536; else if (code == 2'd2) gsz = 16384;
    end else begin
      if (code == 2'd2) gsz = 4096; else if (code == 2'd1) gsz = 16384; else if (code == 2'd3) gsz = 65536;
    end
    if (gsz == 0) return;
    off = 0;
    while ((64'd1 << off) != gsz) off++;
    iw = off - 3;
    for (int l = 0; l < 4; l++) sh[l] = off + (3 - l) * iw;
    if (gsz == 4096) start = (vs > sh[0]) ? 0 : ((vs > sh[1]) ? 1 : 2);
    else             start = (vs > sh[1]) ? 1 : 2;
    tb = hi ? root_hi : root_lo;
    om = (64'd1 << off) - 1;
    for (int l = start; l < 4; l++) begin
      idx = (va >> sh[l]) & ((64'd1 << iw) - 1);
      a   = tb + idx * 8;
      if (build) begin
        built_addr.push_back(a);
        if (l == 3) mem_m[a] = page_base | 64'hC03;
        else if (!mem_m.exists(a)) begin
          mem_m[a] = next_tbl | 64'hC03;
          next_tbl += 64'h10_0000;
        end
      end else exp_addr.push_back(a);
      d = rd(a);
      if (d[1:0] != 2'b11) return;
      if (l == 3) begin flt = 0; pa = (d & ~om) | (va & om); return; end
      tb = d & ~om;
    end
  endtask

  task automatic step();
    bit          f;
    logic [63:0] p, ea;
    @(negedge clk);
    cyc++;
    if (cyc > WD_LIMIT) begin
      n_err++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
    // R12: one done pulse, cycle exact; ready only when idle
    chk(done === exp_done, "R12", "done", {63'd0, done}, {63'd0, exp_done});
    if (exp_done) begin
      chk(done_fault === exp_fault, cur_tag, "fault", {63'd0, done_fault}, {63'd0, exp_fault});
      if (!exp_fault) chk(done_paddr === exp_pa, cur_tag, "paddr", done_paddr, exp_pa);
    end
    chk(req_ready === !exp_busy, "R12", "ready", {63'd0, req_ready}, {63'd0, !exp_busy});
    mem_rd_valid = 1'b0;
    exp_done     = 0;
    if (resp_wait) begin
      resp_cnt--;
      if (resp_cnt == 0) begin
        resp_wait    = 0;
        mem_rd_valid = 1'b1;
        mem_rd_data  = rd(resp_addr);
        if (exp_addr.size() == 0) begin
          exp_done  = 1;
          exp_fault = pend_fault;
          exp_pa    = pend_pa;
          exp_busy  = 0;
        end
      end
    end else if (stray && !exp_busy) begin
      stray        = 0;
      mem_rd_valid = 1'b1;
      mem_rd_data  = 64'h0000_0000_0000_0C03;
    end
    if (mem_rd_req) begin
      if (exp_addr.size() == 0) chk(0, "R9", "unexpected read", mem_rd_addr, 64'd0);
      else begin
        ea = exp_addr.pop_front();
        // R9: descriptor address sequence
        chk(mem_rd_addr === ea, "R9", "read addr", mem_rd_addr, ea);
      end
      resp_wait = 1;
      resp_cnt  = lat;
      resp_addr = mem_rd_addr;
    end
    req_valid = 1'b0;
    if (launch) begin
      launch    = 0;
      req_vaddr = l_va;
      xlat_en   = l_en;
      ctl_word  = l_ctl;
      req_valid = 1'b1;
      ref_walk(l_va, l_en, l_ctl, 0, f, p);
      if (exp_addr.size() == 0) begin
        exp_done = 1; exp_fault = f; exp_pa = p;
      end else begin
        exp_busy = 1; pend_fault = f; pend_pa = p;
      end
    end else if (poke && exp_busy) begin
      poke      = 0;
      req_valid = 1'b1;
      req_vaddr = 64'h0000_0000_DEAD_BEEF;
    end
  endtask

  task automatic prep(input logic [63:0] va, input logic en, input logic [31:0] ctl);
    bit          f;
    logic [63:0] p;
    mem_m.delete();
    built_addr.delete();
    next_tbl = 64'h0000_0000_2000_0000;
    ref_walk(va, en, ctl, 1, f, p);
  endtask

  task automatic run(input string tag, input logic [63:0] va, input logic en,
                     input logic [31:0] ctl, input int latency);
    int guard = 0;
    cur_tag = tag;
    lat     = latency;
    l_va    = va;
    l_en    = en;
    l_ctl   = ctl;
    launch  = 1;
    step();
    do begin
      step();
      guard++;
    end while ((exp_busy || exp_done) && guard < 300);
    if (guard >= 300) chk(0, tag, "walk hung", 64'd0, 64'd1);
  endtask

  task automatic walk(input string tag, input logic [63:0] va, input logic en,
                      input logic [31:0] ctl, input int latency);
    prep(va, en, ctl);
    run(tag, va, en, ctl, latency);
  endtask

  initial begin
    logic [31:0] c4;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12: reset state
    step();
    chk(mem_rd_req === 1'b0, "R12", "reset rd_req", {63'd0, mem_rd_req}, 64'd0);

    walk("R1", 64'hFFFF_0000_1234_5678, 1'b0, mk_ctl(16, 0, 16, 2), 1);

    c4 = mk_ctl(16, 0, 16, 2);
    walk("R7", 64'h0000_7A5B_3C2D_1E0F, 1'b1, c4, 1);
    walk("R7", 64'h0000_0045_6789_ABCD, 1'b1, mk_ctl(25, 0, 16, 2), 2);
    walk("R7", 64'h0000_0000_2ABC_DEF1, 1'b1, mk_ctl(34, 0, 16, 2), 3);
    walk("R3", 64'h0000_FFFF_FFFF_FFFF, 1'b1, c4, 2);

    walk("R5", 64'h0000_1234_5678_9ABC, 1'b1, mk_ctl(16, 2, 16, 2), 1);
    walk("R8", 64'h0000_0321_4567_89AB, 1'b1, mk_ctl(22, 1, 16, 2), 2);
    walk("R8", 64'h0000_F0E1_D2C3_B4A5, 1'b1, mk_ctl(16, 1, 16, 2), 1);

    walk("R2", 64'hFFFF_8123_4567_89AB, 1'b1, c4, 1);
    walk("R6", 64'hFFFF_F876_5432_1098, 1'b1, mk_ctl(16, 0, 20, 1), 3);
    walk("R6", 64'hFFFF_ABCD_EF01_2345, 1'b1, mk_ctl(16, 0, 16, 3), 2);

    walk("R3", 64'h0001_0000_0000_0000, 1'b1, c4, 1);
    walk("R4", 64'hFFFE_8000_0000_0000, 1'b1, c4, 1);
    walk("R5", 64'h0000_0000_1000_0000, 1'b1, mk_ctl(16, 3, 16, 2), 1);
    walk("R6", 64'hFFFF_8000_1000_0000, 1'b1, mk_ctl(16, 0, 16, 0), 1);

    // R10: invalid descriptor at the second level
    prep(64'h0000_7A5B_3C2D_1E0F, 1'b1, c4);
    mem_m[built_addr[1]] = mem_m[built_addr[1]] & ~64'd1;
    run("R10", 64'h0000_7A5B_3C2D_1E0F, 1'b1, c4, 2);
    // R10: block encoding 01 at level 2
    prep(64'h0000_7A5B_3C2D_1E0F, 1'b1, c4);
    mem_m[built_addr[2]] = (mem_m[built_addr[2]] & ~64'd3) | 64'd1;
    run("R10", 64'h0000_7A5B_3C2D_1E0F, 1'b1, c4, 1);
    // R10: 01 at the last level
    prep(64'h0000_7A5B_3C2D_1E0F, 1'b1, c4);
    mem_m[built_addr[3]] = page_base | 64'd1;
    run("R10", 64'h0000_7A5B_3C2D_1E0F, 1'b1, c4, 1);

    // R11: attribute bits in table and page descriptors are masked
    prep(64'h0000_1234_5678_9ABC, 1'b1, mk_ctl(16, 2, 16, 2));
    mem_m[built_addr[0]] = mem_m[built_addr[0]] | 64'h3FF0;
    run("R11", 64'h0000_1234_5678_9ABC, 1'b1, mk_ctl(16, 2, 16, 2), 1);

    // R12: request while busy ignored, stray valid while idle ignored
    prep(64'h0000_7A5B_3C2D_1E0F, 1'b1, c4);
    poke = 1;
    run("R12", 64'h0000_7A5B_3C2D_1E0F, 1'b1, c4, 3);
    stray = 1;
    repeat (4) step();

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule